// File: doc/BRIEF.md
# Square Channel Frequency Sweep Unit

This block moves the 11-bit pitch value of a square-wave tone channel up or down at regular intervals. It keeps its own working copy of the frequency, which is loaded when the channel is triggered. A 3-bit sweep timer is advanced by a 128 Hz strobe. Each time the timer runs out, the block computes a new frequency from the working copy: it shifts the copy right, adds the shifted value to it or subtracts it, and checks the result against the 11-bit range. The waveform generator that uses this frequency sits outside the block.

The host logic provides the sweep settings (interval, direction and step shift), the channel frequency, a one-cycle trigger pulse and the sweep strobe. The block returns the updated frequency with a one-cycle write-back strobe, so the frequency register can be refreshed. It also returns a one-cycle kill pulse. The kill pulse fires when a computed frequency would not fit in 11 bits, and it tells the channel to switch off. An overflow can already be detected at trigger time, before any sweep step has run.

Top module: `freq_sweep`

## Requirements
- R1: While reset is held, and in the first cycle after it, `freq_o` is 0 and `freq_we_o` and `kill_o` are low.
- R2: A trigger loads `freq_i` into the working copy, which `freq_o` shows from the next cycle. A trigger never raises `freq_we_o`.
- R3: On a trigger with `shift_i` non-zero, the new frequency of `freq_i` is computed. If that value is above 2047, `kill_o` pulses in the cycle after the trigger. On a trigger with `shift_i` = 0, no check is made, so `freq_i` = 2047 does not kill.
- R4: The new frequency is F + (F >> shift) when `negate_i` = 0 and F − (F >> shift) when `negate_i` = 1, where F is the working copy.
- R5: A trigger or an expiry reloads the sweep timer with `period_i`, and a period of 0 reloads as 8. Each strobe on `tick_i` counts the timer down by one, and a sweep step runs on the strobe that brings it to expiry. With period 2, that is every second strobe.
- R6: A sweep step runs only if the enable flag was set at trigger (period or shift non-zero) and `period_i` is non-zero at expiry. Otherwise an expiry changes nothing.
- R7: If a sweep step gives a result of 2047 or less and `shift_i` is non-zero, the result is stored as the working copy. In the cycle after the strobe, `freq_o` shows the result and `freq_we_o` is high for one cycle.
- R8: If a sweep step gives a result above 2047, `kill_o` pulses in the cycle after the strobe, and neither the frequency nor the write strobe changes.
- R9: After each stored result, a second computation is made from the stored value, and it is not kept. If it overflows, `kill_o` pulses in the same cycle as `freq_we_o`.
- R10: A sweep step with `shift_i` = 0 never writes the frequency back, but its overflow check still runs. For example, 2047 with upward direction gives 4094, which kills.
- R11: A kill clears the enable flag. After that, no sweep step runs until the next trigger.
- R12: A trigger and a strobe in the same cycle act as a trigger alone: the timer reloads and no sweep step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Channel trigger pulse |
| tick_i | input | 1 | 128 Hz sweep strobe, one cycle wide |
| period_i | input | 3 | Sweep interval in strobes (0 reloads as 8) |
| negate_i | input | 1 | 1 = sweep downward |
| shift_i | input | 3 | Right-shift amount for each step |
| freq_i | input | 11 | Current channel frequency register |
| freq_o | output | 11 | Working frequency copy |
| freq_we_o | output | 1 | One-cycle write-back strobe for `freq_o` |
| kill_o | output | 1 | One-cycle channel-disable pulse |

## Verification
The bench builds the block with its default parameters: 11-bit frequency, 3-bit period and 3-bit shift. With these values the 2047 limit can be reached exactly. Near that limit, a result of exactly 2047 is stored and 2048 or more kills. The largest interval of eight strobes is used for period 0. The full shift of seven is also covered, and at that shift a small frequency keeps its value when written back.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    localparam int DEF_FREQ_W = 11;
    localparam int DEF_CTRL_W = 3;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;
endpackage

// File: rtl/sweep_step_calc.sv
// One frequency step: F +/- (F >> shift), with an out-of-range flag.
module sweep_step_calc
    import sweep_pkg::*;
#(
    parameter int FREQ_W  = DEF_FREQ_W,
    parameter int SHIFT_W = DEF_CTRL_W
) (
    input  logic [FREQ_W-1:0]  base_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  sweep_dir_e         dir_i,
    output logic [FREQ_W-1:0]  result_o,
    output logic               ovf_o
);
    localparam int SUM_W = FREQ_W + 1;

    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] delta_ext;
    logic [SUM_W-1:0] sum;

    always_comb begin
        base_ext  = {1'b0, base_i};
        delta_ext = {1'b0, base_i >> shift_i};
        if (dir_i == DIR_DOWN) begin
            sum = base_ext - delta_ext;
        end else begin
            sum = base_ext + delta_ext;
        end
        result_o = sum[FREQ_W-1:0];
        ovf_o    = sum[FREQ_W];
    end
endmodule

// File: rtl/sweep_timer.sv
// Down-counter advanced by the sweep strobe; zero period reloads as 2**PERIOD_W.
module sweep_timer #(
    parameter int PERIOD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                expire_o
);
    localparam int CNT_W = PERIOD_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << PERIOD_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] reload_val;

    always_comb begin
        reload_val = (period_i == '0) ? FULL_CNT : {1'b0, period_i};
        expire_o   = tick_i && !load_i && (cnt_q <= CNT_W'(1));
        cnt_d      = cnt_q;
        if (load_i || expire_o) begin
            cnt_d = reload_val;
        end else if (tick_i) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/freq_sweep.sv
module freq_sweep
    import sweep_pkg::*;
#(
    parameter int FREQ_W   = DEF_FREQ_W,
    parameter int PERIOD_W = DEF_CTRL_W,
    parameter int SHIFT_W  = DEF_CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                negate_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    input  logic [FREQ_W-1:0]   freq_i,
    output logic [FREQ_W-1:0]   freq_o,
    output logic                freq_we_o,
    output logic                kill_o
);
    localparam int N_STAGE = 2;

    typedef struct packed {
        logic [FREQ_W-1:0] shadow;
        logic              enable;
        logic              we;
        logic              kill;
    } state_t;

    state_t st_d, st_q;

    logic              expire;
    logic [FREQ_W-1:0] stage_in  [N_STAGE];
    logic [FREQ_W-1:0] stage_out [N_STAGE];
    logic              stage_ovf [N_STAGE];
    sweep_dir_e        dir;

    assign dir = negate_i ? DIR_DOWN : DIR_UP;

    sweep_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (trig_i),
        .tick_i   (tick_i),
        .period_i (period_i),
        .expire_o (expire)
    );

    // Stage 0 works on the trigger value or the working copy; stage 1 re-checks stage 0's result.
    assign stage_in[0] = trig_i ? freq_i : st_q.shadow;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign stage_in[g] = stage_out[g-1];
        end
        sweep_step_calc #(
            .FREQ_W  (FREQ_W),
            .SHIFT_W (SHIFT_W)
        ) u_calc (
            .base_i   (stage_in[g]),
            .shift_i  (shift_i),
            .dir_i    (dir),
            .result_o (stage_out[g]),
            .ovf_o    (stage_ovf[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.kill = 1'b0;
        if (trig_i) begin
            st_d.shadow = freq_i;
            st_d.enable = (period_i != '0) || (shift_i != '0);
            if ((shift_i != '0) && stage_ovf[0]) begin
                st_d.kill   = 1'b1;
                st_d.enable = 1'b0;
            end
        end else if (expire && st_q.enable && (period_i != '0)) begin
            if (stage_ovf[0]) begin
                st_d.kill   = 1'b1;
                st_d.enable = 1'b0;
            end else if (shift_i != '0) begin
                st_d.shadow = stage_out[0];
                st_d.we     = 1'b1;
                if (stage_ovf[1]) begin
                    st_d.kill   = 1'b1;
                    st_d.enable = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_o    = st_q.shadow;
    assign freq_we_o = st_q.we;
    assign kill_o    = st_q.kill;
endmodule

// File: rtl/freq_sweep_checker.sv
module freq_sweep_checker #(
    parameter int FREQ_W   = 11,
    parameter int PERIOD_W = 3,
    parameter int SHIFT_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                trig_i,
    input logic                tick_i,
    input logic [PERIOD_W-1:0] period_i,
    input logic                negate_i,
    input logic [SHIFT_W-1:0]  shift_i,
    input logic [FREQ_W-1:0]   freq_i,
    input logic [FREQ_W-1:0]   freq_o,
    input logic                freq_we_o,
    input logic                kill_o
);
    AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (freq_o == $past(freq_i)) && !freq_we_o); // R2

    AST_WE_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we_o |-> ($past(shift_i) != '0) && ($past(period_i) != '0)); // R7

    AST_WE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we_o |-> $past(tick_i) && !$past(trig_i)); // R12

    AST_STEP_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we_o |-> ($past(negate_i) ? (freq_o <= $past(freq_o))
                                       : (freq_o >= $past(freq_o)))); // R4

    AST_KILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> ($past(trig_i) || $past(tick_i))); // R8

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !tick_i) |=> $stable(freq_o) && !freq_we_o && !kill_o); // R5
endmodule

bind freq_sweep freq_sweep_checker #(
    .FREQ_W   (FREQ_W),
    .PERIOD_W (PERIOD_W),
    .SHIFT_W  (SHIFT_W)
) u_freq_sweep_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .tick_i    (tick_i),
    .period_i  (period_i),
    .negate_i  (negate_i),
    .shift_i   (shift_i),
    .freq_i    (freq_i),
    .freq_o    (freq_o),
    .freq_we_o (freq_we_o),
    .kill_o    (kill_o)
);

// File: tb/freq_sweep_bench.sv
`timescale 1ns/1ps
module freq_sweep_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [2:0]  period_i = '0;
    logic        negate_i = 1'b0;
    logic [2:0]  shift_i = '0;
    logic [10:0] freq_i = '0;
    logic [10:0] freq_o;
    logic        freq_we_o;
    logic        kill_o;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    freq_sweep u_freq_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .tick_i    (tick_i),
        .period_i  (period_i),
        .negate_i  (negate_i),
        .shift_i   (shift_i),
        .freq_i    (freq_i),
        .freq_o    (freq_o),
        .freq_we_o (freq_we_o),
        .kill_o    (kill_o)
    );

    typedef struct packed {
        logic [10:0] f;
        logic [2:0]  per;
        logic        neg;
        logic [2:0]  sh;
        logic        tkill;
        logic [10:0] efreq;
        logic        ewe;
        logic        ekill;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{11'd1024, 3'd1, 1'b0, 3'd1, 1'b0, 11'd1536, 1'b1, 1'b1}, // R7 R9
        '{11'd1000, 3'd2, 1'b0, 3'd2, 1'b0, 11'd1250, 1'b1, 1'b0}, // R5 R7
        '{11'd1000, 3'd3, 1'b1, 3'd1, 1'b0, 11'd500,  1'b1, 1'b0}, // R4
        '{11'd2000, 3'd1, 1'b0, 3'd3, 1'b1, 11'd2000, 1'b0, 1'b0}, // R3 R11
        '{11'd2047, 3'd1, 1'b0, 3'd0, 1'b0, 11'd2047, 1'b0, 1'b1}, // R3 R10
        '{11'd100,  3'd1, 1'b1, 3'd0, 1'b0, 11'd100,  1'b0, 1'b0}, // R10
        '{11'd500,  3'd0, 1'b0, 3'd2, 1'b0, 11'd500,  1'b0, 1'b0}, // R6
        '{11'd300,  3'd0, 1'b0, 3'd0, 1'b0, 11'd300,  1'b0, 1'b0}, // R6
        '{11'd1700, 3'd4, 1'b0, 3'd2, 1'b1, 11'd1700, 1'b0, 1'b0}, // R3 R11
        '{11'd1638, 3'd1, 1'b0, 3'd2, 1'b0, 11'd2047, 1'b1, 1'b1}, // R7 R9
        '{11'd7,    3'd1, 1'b0, 3'd3, 1'b0, 11'd7,    1'b1, 1'b0}, // R4
        '{11'd1024, 3'd5, 1'b1, 3'd7, 1'b0, 11'd1016, 1'b1, 1'b0}  // R4 R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_trig(input logic [10:0] f, input logic [2:0] per,
                           input logic neg, input logic [2:0] sh, input logic with_tick);
        @(negedge clk);
        freq_i = f; period_i = per; negate_i = neg; shift_i = sh;
        trig_i = 1'b1; tick_i = with_tick;
        @(negedge clk);
        trig_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 freq", 32'(freq_o), 32'd0);
        check("R1 we", 32'(freq_we_o), 32'd0);
        check("R1 kill", 32'(kill_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 freq after release", 32'(freq_o), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            int n;
            vec_t v;
            v = VECS[i];
            n = (v.per == 3'd0) ? 8 : int'(v.per);
            do_trig(v.f, v.per, v.neg, v.sh, 1'b0);
            check("R2 trigger load", 32'(freq_o), 32'(v.f));
            check("R2 no write on trigger", 32'(freq_we_o), 32'd0);
            check("R3 trigger kill", 32'(kill_o), 32'(v.tkill));
            for (int t = 1; t < n; t++) begin
                do_tick();
                check("R5 no step before expiry", 32'({freq_we_o, kill_o}), 32'd0);
            end
            do_tick();
            check("R4/R7 swept freq", 32'(freq_o), 32'(v.efreq));
            check("R7 write strobe", 32'(freq_we_o), 32'(v.ewe));
            check("R8/R9 kill at expiry", 32'(kill_o), 32'(v.ekill));
        end

        // R8: first step overflows -> kill, no write
        do_trig(11'd1800, 3'd1, 1'b0, 3'd0, 1'b0);
        do_tick();
        check("R8 kill", 32'(kill_o), 32'd1);
        check("R8 no write", 32'(freq_we_o), 32'd0);
        check("R8 freq held", 32'(freq_o), 32'd1800);

        // R11: after kill, further expiries do nothing
        do_tick();
        check("R11 no step after kill", 32'({freq_we_o, kill_o}), 32'd0);
        check("R11 freq held", 32'(freq_o), 32'd1800);

        // R12: trigger with strobe in same cycle
        do_trig(11'd1024, 3'd1, 1'b0, 3'd1, 1'b1);
        check("R12 no step on trigger", 32'(freq_we_o), 32'd0);
        check("R12 freq loaded", 32'(freq_o), 32'd1024);
        do_tick();
        check("R12 step after reload", 32'(freq_o), 32'd1536);

        // R5: repeated sweeps with period 2, downward
        do_trig(11'd1024, 3'd2, 1'b1, 3'd2, 1'b0);
        do_tick(); do_tick();
        check("R5 first sweep", 32'(freq_o), 32'd768);
        do_tick();
        check("R5 idle tick", 32'(freq_we_o), 32'd0);
        do_tick();
        check("R5 second sweep", 32'(freq_o), 32'd576);

        // R6: period changed to 0 after trigger stops stepping
        do_trig(11'd400, 3'd1, 1'b0, 3'd1, 1'b0);
        @(negedge clk);
        period_i = 3'd0;
        for (int t = 0; t < 8; t++) do_tick();
        check("R6 period zero at expiry", 32'(freq_o), 32'd400);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule